// File: doc/BRIEF.md
# Fuse-Programmed Sum-of-Products Logic Array with Per-Output Enables

This block is a purely combinational programmable logic array. A flat configuration vector sets, row by row, which input literals enter each of 64 AND terms. The terms are grouped into eight bands, one band per output channel. In each band, one term decides whether the channel drives its pin. The other seven terms are ORed and inverted, so each channel produces an active-low level.

Ten dedicated inputs feed the array. Two channels (0 and 7) go to output-only pins. The six channels in between go to bidirectional pins. The value seen on each bidirectional pin is fed back into the array. A channel whose enable term is false therefore turns its pin into one more array input.

Bidirectional pins appear as three separate signals: the level the block would drive, the enable, and the value observed on the pin. There is no clock and no stored state; the outputs follow the inputs directly.

Top module: `pal_andor_array`

## Requirements
- R1: Configuration bit `row*32 + col` belongs to term `row` (0..63). Array signal `s` has its true literal in column `2s` and its complement in column `2s+1`. Signals 0..9 are `inPins[0..9]` and signals 10..15 are `ioIn[0..5]`.
- R2: A configuration bit of 1 connects its literal into the term, and a term is true only when every connected literal is 1. A row of all ones is therefore false for every input, and a row of all zeros is always true.
- R3: Band `k` occupies rows `8k..8k+7`, and `outEnable[k]` equals the value of row `8k`.
- R4: `outLevel[k]` is the inverse of the OR of rows `8k+1` through `8k+7`. The last row of a band takes part like the others.
- R5: Channels 1..6 are bidirectional, and channel `k` observes `ioIn[k-1]`. The array always reads the observed pin value, whether the channel is enabled or not. A disabled channel's pin thus acts as an input, and an enabled channel's pin feeds back the value actually present on it.
- R6: The block has no clock. A change on any input appears on `outLevel` and `outEnable` without any clock edge.
- R7: A channel whose enable is 0 still presents its computed level on `outLevel`. Only `outEnable` reflects the enable term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fuseMap | input | 2048 | Configuration bits; 1 = literal connected |
| inPins | input | 10 | Dedicated array inputs |
| ioIn | input | 6 | Values observed on the six bidirectional pins (channels 1..6) |
| outLevel | output | 8 | Active-low level each channel would drive |
| outEnable | output | 8 | Per-channel drive enable from the band's first term |

## Verification
An erased configuration and a fully blown one pin down the two extremes of the AND term: never true and always true. A folded 4-to-16 decoder, swept over every value of all ten dedicated inputs, checks the fuse addressing, the literal polarity and the OR of a band's first and last sum rows. It also shows that unconnected inputs have no effect.

A second map disables the six bidirectional channels and decodes their pin values on the two output-only channels, over all 64 pin patterns. This separates feedback taken from the pin from feedback taken from the driven level. A third map drives an enable from an input while another channel reads that same pin against a contradicting value, and back-to-back input changes with no clock edge between them confirm the path is combinational.

// File: rtl/pal_array_pkg.sv
package pal_array_pkg;
  localparam int NUM_DED_IN     = 10;
  localparam int NUM_IO         = 6;
  localparam int NUM_OUT        = 8;
  localparam int TERMS_PER_BAND = 8;
  localparam int FIRST_IO_CH    = 1;
  localparam int ARRAY_SIGS     = NUM_DED_IN + NUM_IO;
  localparam int NUM_COLS       = 2 * ARRAY_SIGS;
  localparam int NUM_ROWS       = NUM_OUT * TERMS_PER_BAND;
  localparam int SUM_PER_BAND   = TERMS_PER_BAND - 1;
  localparam int FUSE_BITS      = NUM_ROWS * NUM_COLS;

  // strobes from the enable control to the output datapath
  typedef struct packed {
    logic [NUM_OUT-1:0] drive;
  } ctlStrobes_t;
endpackage

// File: rtl/pal_literal_gen.sv
module pal_literal_gen #(
  parameter int DED_IN = pal_array_pkg::NUM_DED_IN,
  parameter int IO_CNT = pal_array_pkg::NUM_IO
) (
  input  logic [DED_IN-1:0]            inPins,
  input  logic [IO_CNT-1:0]            ioIn,
  output logic [2*(DED_IN+IO_CNT)-1:0] litVec
);
  localparam int SIGS = DED_IN + IO_CNT;

  logic [SIGS-1:0] arraySig;
  assign arraySig = {ioIn, inPins};

  // true literal on the even column, complement on the odd one
  for (genvar s = 0; s < SIGS; s++) begin : g_lit
    assign litVec[2*s]   = arraySig[s];
    assign litVec[2*s+1] = ~arraySig[s];
  end
endmodule

// File: rtl/pal_term_array.sv
module pal_term_array #(
  parameter int COLS = pal_array_pkg::NUM_COLS,
  parameter int ROWS = pal_array_pkg::NUM_ROWS
) (
  input  logic [ROWS*COLS-1:0] fuseMap,
  input  logic [COLS-1:0]      litVec,
  output logic [ROWS-1:0]      termVec
);
  localparam int PAIRS = COLS / 2;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] rowFuses;
    assign rowFuses   = fuseMap[r*COLS +: COLS];
    // a connected literal must be 1; a disconnected one is ignored
    assign termVec[r] = &(litVec | ~rowFuses);

    always_comb begin
      // R2
      erasedRow_chk: assert (!(&rowFuses) || !termVec[r]);
      // R2
      blownRow_chk: assert ((|rowFuses) || termVec[r]);
    end
  end

  always_comb begin
    for (int s = 0; s < PAIRS; s++) begin
      // R1
      litPair_chk: assert (litVec[2*s] != litVec[2*s+1]);
    end
  end
endmodule

// File: rtl/pal_enable_ctl.sv
module pal_enable_ctl #(
  parameter int OUTS = pal_array_pkg::NUM_OUT
) (
  input  logic [OUTS-1:0]                  enableRows,
  output pal_array_pkg::ctlStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    for (int k = 0; k < OUTS; k++) begin
      strobes.drive[k] = enableRows[k];
    end
  end
endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
  parameter int OUTS = pal_array_pkg::NUM_OUT,
  parameter int SUMS = pal_array_pkg::SUM_PER_BAND
) (
  input  logic [OUTS*SUMS-1:0]        sumRows,
  input  pal_array_pkg::ctlStrobes_t  strobes,
  output logic [OUTS-1:0]             outLevel,
  output logic [OUTS-1:0]             outEnable
);
  for (genvar k = 0; k < OUTS; k++) begin : g_band
    logic [SUMS-1:0] bandSum;
    assign bandSum     = sumRows[k*SUMS +: SUMS];
    assign outLevel[k] = ~(|bandSum);
    assign outEnable[k] = strobes.drive[k];

    always_comb begin
      for (int j = 0; j < SUMS; j++) begin
        // R4
        orPlaneLow_chk: assert (!bandSum[j] || !outLevel[k]);
      end
    end
  end
endmodule

// File: rtl/pal_andor_array.sv
module pal_andor_array
  import pal_array_pkg::*;
(
  input  logic [FUSE_BITS-1:0]  fuseMap,
  input  logic [NUM_DED_IN-1:0] inPins,
  input  logic [NUM_IO-1:0]     ioIn,
  output logic [NUM_OUT-1:0]    outLevel,
  output logic [NUM_OUT-1:0]    outEnable
);
  logic [NUM_COLS-1:0]             litVec;
  logic [NUM_ROWS-1:0]             termVec;
  logic [NUM_OUT-1:0]              enableRows;
  logic [NUM_OUT*SUM_PER_BAND-1:0] sumRows;
  ctlStrobes_t                     strobes;

  pal_literal_gen #(.DED_IN(NUM_DED_IN), .IO_CNT(NUM_IO)) u_lit (
    .inPins (inPins),
    .ioIn   (ioIn),
    .litVec (litVec)
  );

  pal_term_array #(.COLS(NUM_COLS), .ROWS(NUM_ROWS)) u_terms (
    .fuseMap (fuseMap),
    .litVec  (litVec),
    .termVec (termVec)
  );

  // split each band: first row to control, remaining rows to the OR plane
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_split
    assign enableRows[k] = termVec[k*TERMS_PER_BAND];
    assign sumRows[k*SUM_PER_BAND +: SUM_PER_BAND] =
      termVec[k*TERMS_PER_BAND+1 +: SUM_PER_BAND];
  end

  pal_enable_ctl #(.OUTS(NUM_OUT)) u_ctl (
    .enableRows (enableRows),
    .strobes    (strobes)
  );

  pal_or_plane #(.OUTS(NUM_OUT), .SUMS(SUM_PER_BAND)) u_or (
    .sumRows   (sumRows),
    .strobes   (strobes),
    .outLevel  (outLevel),
    .outEnable (outEnable)
  );

  always_comb begin
    for (int k = 0; k < NUM_OUT; k++) begin
      // R3
      enableRow_chk: assert (outEnable[k] == termVec[k*TERMS_PER_BAND]);
    end
    for (int j = 0; j < NUM_IO; j++) begin
      // R5
      ioFeedback_chk: assert (litVec[2*(NUM_DED_IN+j)] == ioIn[j]);
    end
  end
endmodule

// File: tb/sim_pal_andor_array.sv
module sim_pal_andor_array;
  import pal_array_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [FUSE_BITS-1:0]  fmap;
  logic [NUM_DED_IN-1:0] inPins;
  logic [NUM_IO-1:0]     ioIn;
  logic [NUM_OUT-1:0]    outLevel, outEnable;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  pal_andor_array u0 (
    .fuseMap   (fmap),
    .inPins    (inPins),
    .ioIn      (ioIn),
    .outLevel  (outLevel),
    .outEnable (outEnable)
  );

  task automatic cmp(string req, string what, logic [NUM_OUT-1:0] act, logic [NUM_OUT-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b (in=%b io=%b)", req, what, act, exp, inPins, ioIn);
    end
  endtask

  task automatic eraseAll();
    fmap = '1;
  endtask

  task automatic openRow(int row);
    fmap[row*NUM_COLS +: NUM_COLS] = '0;
  endtask

  task automatic addLit(int row, int sig, bit trueLit);
    fmap[row*NUM_COLS + 2*sig + (trueLit ? 0 : 1)] = 1'b1;
  endtask

  task automatic applyAt(logic [NUM_DED_IN-1:0] a, logic [NUM_IO-1:0] b);
    @(posedge clk);
    inPins = a;
    ioIn   = b;
    @(negedge clk);
  endtask

  function automatic logic [NUM_OUT-1:0] decExp(logic [3:0] v);
    logic [NUM_OUT-1:0] r;
    for (int k = 0; k < NUM_OUT; k++) r[k] = ~((v == k) || (v == k + 8));
    return r;
  endfunction

  task automatic loadDecoder();
    eraseAll();
    for (int k = 0; k < NUM_OUT; k++) begin
      openRow(8*k);
      openRow(8*k+1);
      openRow(8*k+7);
      for (int b = 0; b < 4; b++) begin
        addLit(8*k+1, b, ((k >> b) & 1) == 1);
        addLit(8*k+7, b, (((k + 8) >> b) & 1) == 1);
      end
    end
  endtask

  // R2: erased map gives all terms false
  task automatic testErased();
    eraseAll();
    for (int i = 0; i < 4; i++) begin
      applyAt(10'(i * 341), 6'(i * 21));
      cmp("R2", "erased level", outLevel, 8'hFF);
      cmp("R2", "erased enable", outEnable, 8'h00);
    end
  endtask

  // R2: fully blown map gives all terms true
  task automatic testBlown();
    fmap = '0;
    for (int i = 0; i < 3; i++) begin
      applyAt(10'(i * 500 + 7), 6'(i * 19));
      cmp("R2", "blown level", outLevel, 8'h00);
      cmp("R2", "blown enable", outEnable, 8'hFF);
    end
  endtask

  // R1 R3 R4: folded decoder over all dedicated input values
  task automatic testDecoder();
    loadDecoder();
    for (int v = 0; v < 1024; v++) begin
      applyAt(10'(v), 6'(v * 5));
      cmp("R4", "decoder level", outLevel, decExp(4'(v)));
      if (v % 64 == 0) cmp("R3", "decoder enable", outEnable, 8'hFF);
    end
  endtask

  // R5 R7: I/O pins as inputs, disabled channels still show level
  task automatic testIoInputs();
    eraseAll();
    openRow(0);
    openRow(1); addLit(1, 10, 1'b1); addLit(1, 11, 1'b1);
    openRow(2); addLit(2, 12, 1'b0); addLit(2, 13, 1'b1);
    openRow(56);
    openRow(57); addLit(57, 14, 1'b1); addLit(57, 15, 1'b0);
    openRow(58); addLit(58, 14, 1'b0); addLit(58, 15, 1'b1);
    for (int k = 1; k <= 6; k++) openRow(8*k+1);
    for (int p = 0; p < 64; p++) begin
      logic [NUM_OUT-1:0] exp;
      logic [5:0] io;
      io = 6'(p);
      exp = 8'h00;
      exp[0] = ~((io[0] & io[1]) | (~io[2] & io[3]));
      exp[7] = ~(io[4] ^ io[5]);
      applyAt(10'(p * 37), io);
      cmp("R5", "io-input level", outLevel, exp);
      cmp("R7", "io-input enable", outEnable, 8'b1000_0001);
    end
  endtask

  // R3 R5: enable from input, feedback from pin while driving
  task automatic testEnableFeedback();
    eraseAll();
    openRow(8);  addLit(8, 9, 1'b1);
    openRow(9);  addLit(9, 0, 1'b1);
    openRow(0);
    openRow(1);  addLit(1, 10, 1'b1);
    for (int c = 0; c < 8; c++) begin
      logic [NUM_DED_IN-1:0] a;
      logic [NUM_IO-1:0] b;
      logic [NUM_OUT-1:0] expL, expE;
      a = '0; a[9] = c[0]; a[0] = c[1];
      b = '0; b[0] = c[2];
      expE = 8'h00; expE[0] = 1'b1; expE[1] = c[0];
      expL = 8'hFF; expL[1] = ~c[1]; expL[0] = ~c[2];
      applyAt(a, b);
      cmp("R3", "input-driven enable", outEnable, expE);
      cmp("R5", "pin feedback level", outLevel, expL);
    end
  endtask

  // R6: outputs follow inputs with no clock edge in between
  task automatic testNoClock();
    loadDecoder();
    @(negedge clk);
    inPins = 10'd3; ioIn = '0;
    #1 cmp("R6", "no-edge level a", outLevel, decExp(4'd3));
    inPins = 10'd13;
    #1 cmp("R6", "no-edge level b", outLevel, decExp(4'd13));
  endtask

  initial begin
    fmap = '1;
    inPins = '0;
    ioIn = '0;
    repeat (3) @(posedge clk);
    testErased();
    testBlown();
    testDecoder();
    testIoInputs();
    testEnableFeedback();
    testNoClock();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule